// File: doc/BRIEF.md
# Byte-Level I2C Master Controller

This block is an I2C master that a host drives one bus step at a time through three byte-wide registers: a command/flag register, a transmit data register and a read-only result code. Each command is one bus event: a start condition, one byte with its acknowledge clock, or a stop condition. When the event finishes, the block posts a result code and raises its attention flag. It then parks with SCL pulled low until the host clears that flag. A whole transfer is therefore a chain of short handshakes, and the host decides each next step from the posted code.

The bus side is open-drain. `scl_oe` and `sda_oe` pull the corresponding line low when high, and `scl_in`/`sda_in` carry the sampled line levels. The SCL half period is a base count shifted left by a 3-bit rate field. The block notices when another master wins the bus, gives up both lines at once and reports the loss. It does not act as a slave and does not wait on a slave that stretches the clock.

Register selection on `reg_sel` is 0 for command, 1 for data, 2 for result code, and 3 reads zero. The command register has this layout: bit 5 is GO (request a start), bit 4 is HALT (request a stop), bit 3 is the attention flag ATTN, bits 2:0 are the rate, and bits 7:6 read zero.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset, the result code reads 0xF8, the command register reads 0x00, the data register reads 0x00, `irq` is 0, and both `scl_oe` and `sda_oe` are 0.
- R2: A command write from idle with bit 5 set and bit 3 clear waits until SCL and SDA have both been high for one full half period. The block then pulls SDA low while SCL is high, pulls SCL low, posts 0x08 and sets ATTN.
- R3: Each SCL high phase and low phase lasts HALF_BASE << rate clock cycles. The rate used is the bits 2:0 of the command write that launched the step.
- R4: ATTN (bit 3, also on `irq`) is set with every posted step result. While it is set and the code is not 0x38, SCL stays pulled low and no bus activity occurs. Writing the command register with bit 3 set neither clears the flag nor launches a step.
- R5: From the parked state, a command write with bits 4 and 3 clear sends the data register MSB first on eight clocks. SDA is then released for a ninth clock, on which the receiver's acknowledge (SDA low) is sampled.
- R6: The first byte after a start posts 0x18 when acknowledged and 0x20 when not.
- R7: Every later byte posts 0x28 when acknowledged and 0x30 when not.
- R8: If SDA reads low at the end of an SCL high phase in which the block released it for a 1 bit, both lines are released and 0x38 is posted with ATTN set. The next command write with bit 3 clear returns the code to 0xF8 with ATTN clear, and the bus stays untouched.
- R9: From the parked state, a command write with bit 4 set and bit 3 clear gives a stop condition: SDA low, then SCL released, then SDA released while SCL is high. The code then becomes 0xF8 and ATTN stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 data, 2 result code |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Attention flag (command bit 3) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
A step sequencer stuck in the wrong state shows up right away at the ports. Either `irq` never rises and SCL stays released when it should be parked low, or it is pulled low when it should be free. A mistracked first-byte flag shows within one byte as a 0x28/0x30 where 0x18/0x20 was due, or the reverse. A bit counter or shift register off by one corrupts the byte seen by the bench's bus monitor on the ninth clock. A wrongly latched rate shows on the very next SCL high phase as a length other than HALF_BASE << rate.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W = 8;
    localparam int RATE_W = 3;

    // command register bit positions
    localparam int CB_GO   = 5;
    localparam int CB_HALT = 4;
    localparam int CB_ATTN = 3;

    // posted result codes
    localparam logic [7:0] RC_IDLE     = 8'hF8;
    localparam logic [7:0] RC_STARTED  = 8'h08;
    localparam logic [7:0] RC_ADR_ACK  = 8'h18;
    localparam logic [7:0] RC_ADR_NACK = 8'h20;
    localparam logic [7:0] RC_DAT_ACK  = 8'h28;
    localparam logic [7:0] RC_DAT_NACK = 8'h30;
    localparam logic [7:0] RC_ARB_LOST = 8'h38;

    typedef enum logic [3:0] {
        E_IDLE, E_WAIT, E_STA_A, E_STA_B,
        E_BIT_LO, E_BIT_HI, E_ACK_LO, E_ACK_HI,
        E_PARK, E_LOST, E_STO_A, E_STO_B, E_STO_C
    } eng_state_e;

    typedef struct packed {
        logic       valid;
        logic       attn;
        logic [7:0] code;
    } step_evt_t;

    function automatic logic [7:0] byte_result(input logic first, input logic acked);
        if (first) return acked ? RC_ADR_ACK : RC_ADR_NACK;
        return acked ? RC_DAT_ACK : RC_DAT_NACK;
    endfunction

endpackage

// File: rtl/i2cm_halfper.sv
module i2cm_halfper #(
    parameter int HALF_BASE = 4,
    parameter int RATE_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int MAX_LIM = HALF_BASE << ((1 << RATE_W) - 1);
    localparam int CW      = $clog2(MAX_LIM + 1);

    logic [RATE_W-1:0] rate_q;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     lim;

    assign lim  = CW'(HALF_BASE << rate_q);
    assign tick = !clr && (cnt == lim - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            rate_q <= '0;
        end else if (clr) begin
            cnt    <= '0;
            rate_q <= rate;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R3: the phase counter never runs past the selected half period
    a_r3_cnt_below_limit: assert property (@(posedge clk) disable iff (rst)
        cnt < lim);

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_go,
    input  logic              cmd_halt,
    input  logic              cmd_start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              tmr_clr,
    output logic              scl_oe,
    output logic              sda_oe,
    output step_evt_t         evt
);
    localparam int NB_W = $clog2(BYTE_W);

    eng_state_e        state, nxt;
    logic [BYTE_W-1:0] shreg;
    logic [NB_W-1:0]   nbit;
    logic              first;
    logic              ld, shf, inc, set_first, clr_first;
    logic              bus_free;

    assign bus_free = scl_in && sda_in;

    always_comb begin
        nxt       = state;
        evt       = '0;
        ld        = 1'b0;
        shf       = 1'b0;
        inc       = 1'b0;
        set_first = 1'b0;
        clr_first = 1'b0;
        case (state)
            E_IDLE:   if (cmd_go && cmd_start) nxt = E_WAIT;
            E_WAIT:   if (tick) nxt = E_STA_A;
            E_STA_A:  if (tick) nxt = E_STA_B;
            E_STA_B:  if (tick) begin
                nxt       = E_PARK;
                evt       = '{valid: 1'b1, attn: 1'b1, code: RC_STARTED};
                set_first = 1'b1;
            end
            E_PARK:   if (cmd_go) begin
                if (cmd_halt) nxt = E_STO_A;
                else begin
                    nxt = E_BIT_LO;
                    ld  = 1'b1;
                end
            end
            E_BIT_LO: if (tick) nxt = E_BIT_HI;
            E_BIT_HI: if (tick) begin
                if (shreg[BYTE_W-1] && !sda_in) begin
                    nxt = E_LOST;
                    evt = '{valid: 1'b1, attn: 1'b1, code: RC_ARB_LOST};
                end else if (nbit == NB_W'(BYTE_W - 1)) begin
                    nxt = E_ACK_LO;
                    shf = 1'b1;
                end else begin
                    nxt = E_BIT_LO;
                    shf = 1'b1;
                    inc = 1'b1;
                end
            end
            E_ACK_LO: if (tick) nxt = E_ACK_HI;
            E_ACK_HI: if (tick) begin
                nxt       = E_PARK;
                evt       = '{valid: 1'b1, attn: 1'b1, code: byte_result(first, !sda_in)};
                clr_first = 1'b1;
            end
            E_LOST:   if (cmd_go) begin
                nxt = E_IDLE;
                evt = '{valid: 1'b1, attn: 1'b0, code: RC_IDLE};
            end
            E_STO_A:  if (tick) nxt = E_STO_B;
            E_STO_B:  if (tick) nxt = E_STO_C;
            E_STO_C:  if (tick) begin
                nxt = E_IDLE;
                evt = '{valid: 1'b1, attn: 1'b0, code: RC_IDLE};
            end
            default:  nxt = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= E_IDLE;
            shreg <= '0;
            nbit  <= '0;
            first <= 1'b0;
        end else begin
            state <= nxt;
            if (ld) begin
                shreg <= tx_byte;
                nbit  <= '0;
            end else if (shf) begin
                shreg <= {shreg[BYTE_W-2:0], 1'b0};
            end
            if (inc) nbit <= nbit + NB_W'(1);
            if (set_first) first <= 1'b1;
            else if (clr_first) first <= 1'b0;
        end
    end

    assign tmr_clr = (state == E_IDLE) || (state == E_PARK) || (state == E_LOST)
                   || ((state == E_WAIT) && !bus_free);

    assign scl_oe = (state == E_STA_B) || (state == E_BIT_LO) || (state == E_ACK_LO)
                  || (state == E_PARK) || (state == E_STO_A);

    assign sda_oe = (state == E_STA_A) || (state == E_STA_B) || (state == E_STO_A)
                  || (state == E_STO_B)
                  || (((state == E_BIT_LO) || (state == E_BIT_HI)) && !shreg[BYTE_W-1]);

    // R2, R9: SDA moves under a released SCL only to form a start or a stop
    a_r2_sda_edge_only_start_stop: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !scl_oe && !$past(scl_oe))
            |-> (state == E_STA_A || state == E_STO_C));

    // R5: the data bit is steady for the whole SCL high phase
    a_r5_bit_steady_high: assert property (@(posedge clk) disable iff (rst)
        (state == E_BIT_HI && $past(state) == E_BIT_HI) |-> $stable(sda_oe));

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
    import i2cm_pkg::*;
#(
    parameter int HALF_BASE = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       scl_in,
    input  logic       sda_in
);
    logic              go_q, halt_q, attn_q;
    logic [RATE_W-1:0] rate_q, rate_eff;
    logic [BYTE_W-1:0] data_q;
    logic [7:0]        code_q;
    logic              ctrl_wr, cmd_go, tmr_clr, tick;
    step_evt_t         evt;

    assign ctrl_wr  = reg_wr && (reg_sel == 2'd0);
    assign cmd_go   = ctrl_wr && !reg_wdata[CB_ATTN];
    assign rate_eff = ctrl_wr ? reg_wdata[RATE_W-1:0] : rate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q   <= 1'b0;
            halt_q <= 1'b0;
            attn_q <= 1'b0;
            rate_q <= '0;
            data_q <= '0;
            code_q <= RC_IDLE;
        end else begin
            if (ctrl_wr) begin
                go_q   <= reg_wdata[CB_GO];
                halt_q <= reg_wdata[CB_HALT];
                rate_q <= reg_wdata[RATE_W-1:0];
                attn_q <= attn_q && reg_wdata[CB_ATTN];
            end
            if (reg_wr && reg_sel == 2'd1) data_q <= reg_wdata;
            if (evt.valid) begin
                code_q <= evt.code;
                if (evt.attn) attn_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (reg_sel)
            2'd0:    reg_rdata = {2'b00, go_q, halt_q, attn_q, rate_q};
            2'd1:    reg_rdata = data_q;
            2'd2:    reg_rdata = code_q;
            default: reg_rdata = 8'h00;
        endcase
    end

    assign irq = attn_q;

    i2cm_halfper #(.HALF_BASE(HALF_BASE), .RATE_W(RATE_W)) u_halfper (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .rate (rate_eff),
        .tick (tick)
    );

    i2cm_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .cmd_go    (cmd_go),
        .cmd_halt  (reg_wdata[CB_HALT]),
        .cmd_start (reg_wdata[CB_GO]),
        .tx_byte   (data_q),
        .tick      (tick),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .tmr_clr   (tmr_clr),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .evt       (evt)
    );

    // R4: a pending attention flag parks SCL low unless the bus was lost
    a_r4_attn_parks_scl: assert property (@(posedge clk) disable iff (rst)
        (attn_q && code_q != RC_ARB_LOST) |-> scl_oe);

    // R8: after a lost arbitration both lines are let go
    a_r8_lost_releases_lines: assert property (@(posedge clk) disable iff (rst)
        (attn_q && code_q == RC_ARB_LOST) |-> (!scl_oe && !sda_oe));

    // R1, R9: the code only changes with the flag raised, or back to idle
    a_r9_code_change_flagged: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_q) |-> (attn_q || code_q == RC_IDLE));

endmodule

// File: tb/i2cm_ctrl_test.sv
`timescale 1ns/1ps
module i2cm_ctrl_test;
    localparam int HB = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd2;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       scl_line, sda_line;
    logic       slave_pull;
    logic       rival_pull = 1'b0;
    logic       ack_en = 1'b1;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | slave_pull | rival_pull);

    i2cm_ctrl #(.HALF_BASE(HB)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_line), .sda_in(sda_line)
    );

    // bus monitor and acknowledging receiver
    logic       prev_scl, prev_sda;
    int         bitcnt, hi_cnt, last_hi, nbytes, nstops;
    logic [7:0] mon_sh, last_byte;

    always @(negedge clk) begin
        if (rst) begin
            prev_scl = 1'b1; prev_sda = 1'b1; bitcnt = 0; hi_cnt = 0;
            last_hi = 0; nbytes = 0; nstops = 0; mon_sh = 8'h00; last_byte = 8'h00;
            slave_pull <= 1'b0;
        end else begin
            if (scl_line && prev_scl && prev_sda && !sda_line) bitcnt = 0;
            else if (scl_line && prev_scl && !prev_sda && sda_line) begin
                bitcnt = 0;
                nstops++;
            end
            if (scl_line && !prev_scl) begin
                if (bitcnt < 8) begin
                    mon_sh = {mon_sh[6:0], sda_line};
                    bitcnt++;
                end else begin
                    bitcnt = 0;
                    last_byte = mon_sh;
                    nbytes++;
                end
            end
            if (!scl_line && prev_scl) begin
                last_hi = hi_cnt;
                slave_pull <= (bitcnt == 8) && ack_en;
            end
            hi_cnt = scl_line ? (prev_scl ? hi_cnt + 1 : 1) : 0;
            prev_scl = scl_line;
            prev_sda = sda_line;
        end
    end

    function automatic logic [7:0] cv(input logic go, input logic halt,
                                      input logic attn, input logic [2:0] rate);
        return {2'b00, go, halt, attn, rate};
    endfunction

    function automatic logic [7:0] exp_code(input logic first, input logic ack);
        if (first) return ack ? 8'h18 : 8'h20;
        return ack ? 8'h28 : 8'h30;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 6000) begin
            @(negedge clk);
            n++;
        end
        chk(irq, req, irq, 1);
    endtask

    task automatic wait_code(input logic [7:0] c, input string req);
        int n = 0;
        logic [7:0] v;
        rd(2'd2, v);
        while (v != c && n < 6000) begin
            rd(2'd2, v);
            n++;
        end
        chk(v == c, req, v, c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int b0, s0;
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd2, v); chk(v == 8'hF8, "R1 code", v, 8'hF8);
        rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
        rd(2'd1, v); chk(v == 8'h00, "R1 data", v, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        chk(scl_oe == 0 && sda_oe == 0, "R1 lines", {scl_oe, sda_oe}, 0);

        // R2 start waits while SDA is held low by another device
        rival_pull = 1'b1;
        wr(2'd0, cv(1, 0, 0, 0));
        repeat (60) @(negedge clk);
        chk(irq == 0 && sda_oe == 0 && scl_oe == 0, "R2 busy wait", {irq, scl_oe, sda_oe}, 0);
        rival_pull = 1'b0;
        wait_irq("R2 start irq");
        rd(2'd2, v); chk(v == 8'h08, "R2 start code", v, 8'h08);

        // R4 writing with bit 3 set neither clears nor launches
        b0 = nbytes;
        wr(2'd0, cv(0, 0, 1, 0));
        repeat (100) @(negedge clk);
        chk(irq == 1 && scl_oe == 1, "R4 parked", {irq, scl_oe}, 2'b11);
        chk(nbytes == b0, "R4 no byte", nbytes, b0);

        // R5/R6 address byte acked, rate 0
        wr(2'd1, 8'hA4);
        ack_en = 1'b1;
        wr(2'd0, cv(0, 0, 0, 0));
        wait_irq("R5 addr irq");
        chk(last_byte == 8'hA4, "R5 addr bits", last_byte, 8'hA4);
        rd(2'd2, v); chk(v == 8'h18, "R6 addr ack", v, 8'h18);
        chk(last_hi == HB, "R3 rate0 high", last_hi, HB);

        // R7 data byte nacked, rate 2
        wr(2'd1, 8'h3C);
        ack_en = 1'b0;
        wr(2'd0, cv(0, 0, 0, 2));
        wait_irq("R7 data irq");
        chk(last_byte == 8'h3C, "R5 data bits", last_byte, 8'h3C);
        rd(2'd2, v); chk(v == 8'h30, "R7 data nack", v, 8'h30);
        chk(last_hi == (HB << 2), "R3 rate2 high", last_hi, HB << 2);

        // R9 stop
        s0 = nstops;
        wr(2'd0, cv(0, 1, 0, 0));
        wait_code(8'hF8, "R9 stop code");
        chk(irq == 0, "R9 irq clear", irq, 0);
        chk(scl_oe == 0 && sda_oe == 0, "R9 lines", {scl_oe, sda_oe}, 0);
        chk(nstops == s0 + 1, "R9 stop seen", nstops, s0 + 1);

        // R8 arbitration loss on first bit
        wr(2'd0, cv(1, 0, 0, 0));
        wait_irq("R8 start irq");
        wr(2'd1, 8'hC2);
        rival_pull = 1'b1;
        wr(2'd0, cv(0, 0, 0, 0));
        wait_irq("R8 lost irq");
        rd(2'd2, v); chk(v == 8'h38, "R8 lost code", v, 8'h38);
        chk(scl_oe == 0 && sda_oe == 0, "R8 released", {scl_oe, sda_oe}, 0);
        rival_pull = 1'b0;
        wr(2'd0, cv(0, 0, 0, 0));
        rd(2'd2, v); chk(v == 8'hF8, "R8 back idle", v, 8'hF8);
        chk(irq == 0, "R8 irq clear", irq, 0);
        repeat (50) @(negedge clk);
        chk(scl_oe == 0 && sda_oe == 0, "R8 bus quiet", {scl_oe, sda_oe}, 0);

        // random transactions
        for (int t = 0; t < 25; t++) begin
            logic [2:0] rate;
            int nb;
            rate = 3'($urandom % 3);
            nb = 1 + ($urandom % 3);
            wr(2'd0, cv(1, 0, 0, rate));
            wait_irq("R2 rnd start");
            rd(2'd2, v); chk(v == 8'h08, "R2 rnd code", v, 8'h08);
            for (int k = 0; k < nb; k++) begin
                logic [7:0] byt;
                logic ack;
                byt = (k == 0) ? {7'($urandom), 1'b0} : 8'($urandom);
                ack = 1'($urandom);
                ack_en = ack;
                wr(2'd1, byt);
                wr(2'd0, cv(0, 0, 0, rate));
                wait_irq("R5 rnd irq");
                chk(last_byte == byt, "R5 rnd bits", last_byte, byt);
                rd(2'd2, v);
                chk(v == exp_code(k == 0, ack), (k == 0) ? "R6 rnd code" : "R7 rnd code",
                    v, exp_code(k == 0, ack));
                chk(last_hi == (HB << rate), "R3 rnd high", last_hi, HB << rate);
            end
            wr(2'd0, cv(0, 1, 0, rate));
            wait_code(8'hF8, "R9 rnd stop");
            chk(irq == 0, "R9 rnd irq", irq, 0);
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule